// File: doc/BRIEF.md
# Time-Division Slot Arbiter for a Shared Memory Port

This block decides, every clock cycle, which of fourteen clients may use a shared memory port. Two memory regions, one external and one internal, are arbitrated side by side. Each region has its own request vector, its own grant vector and its own schedule: a table of 64 slots in which every slot names the client that owns it. A pointer walks through the table one slot per cycle and wraps around. The share of bandwidth a client gets is set by how many slots it owns.

When the owner of the current slot is requesting, the owner is granted. When it is idle, the slot is not wasted. It passes to a fixed fallback that favours low client numbers: the lowest-numbered requesting client wins. Grants are registered and one-hot. Software fills the schedules through an indexed write port. Each write names a region, a slot and a client number. A write that names a client outside the valid range is dropped.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: After reset every slot of both schedules names client 0, both slot pointers are at slot 0, and both grant outputs are all zero while reset is held.
- R2: In each region the slot pointer moves to the next slot on every clock edge out of reset, whether or not any client is requesting, and wraps from slot 63 to slot 0.
- R3: If the client named by the current slot is requesting, that client alone is granted.
- R4: If the current slot's owner is not requesting but at least one other client is, the grant goes to the requesting client with the lowest index.
- R5: If no client of a region is requesting, that region's grant is all zero.
- R6: The grant is a registered result. The request vector and the slot owner sampled at one clock edge decide the grant seen from that edge until the next. Each grant vector has at most one bit set, and bit k stands for client k.
- R7: A write with `cfg_we` high stores `cfg_client` into slot `cfg_slot` of the region chosen by `cfg_region` (0 = external, 1 = internal). Arbitration at that same edge still uses the old entry, and the new entry is used from the following edge on.
- R8: A write whose `cfg_client` is 14 or higher is ignored, and the addressed slot keeps its previous owner.
- R9: The two regions are independent. A write to one region's schedule never changes the other, and each grant depends only on that region's own requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Schedule write strobe |
| cfg_region | input | 1 | Target schedule: 0 external, 1 internal |
| cfg_slot | input | 6 | Slot index to write |
| cfg_client | input | 4 | Client number stored into the slot |
| ext_req | input | 14 | External region requests, bit k = client k |
| int_req | input | 14 | Internal region requests, bit k = client k |
| ext_gnt | output | 14 | External region grant, one-hot or zero |
| int_grant | output | 14 | Internal region grant, one-hot or zero |

## Verification
Every grant lands exactly one edge after the requests that cause it. A schedule write first affects arbitration at the edge after the one that stores it. The bench keeps its own copy of both schedules and its own slot counter, which starts at 0 on the first edge out of reset. It drives each cycle's inputs on the falling edge and works out the expected pair of grants from the copy as it stands before that cycle's write. It queues that pair, and a monitor compares it with the outputs two nanoseconds after the next rising edge. Request patterns are built from the modelled owner where a case needs the owner idle or needs a wrongly stored entry to show up as a different grant.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    // Default geometry of the arbiter
    parameter int unsigned NUM_CLIENTS = 14;
    parameter int unsigned NUM_SLOTS   = 64;
    parameter int unsigned NUM_REGIONS = 2;

    localparam int unsigned CLIENT_W = $clog2(NUM_CLIENTS);
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS);

    // Region select encoding on the write port
    typedef enum logic {
        REGION_EXT = 1'b0,
        REGION_INT = 1'b1
    } region_e;

endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
    parameter int unsigned NCLI  = tdm_arb_pkg::NUM_CLIENTS,
    parameter int unsigned NSLOT = tdm_arb_pkg::NUM_SLOTS,
    localparam int unsigned CW   = $clog2(NCLI),
    localparam int unsigned SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [CW-1:0] wr_client,
    output logic [CW-1:0] owner
);

    localparam logic [CW-1:0] LAST_CLI  = CW'(NCLI - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOT - 1);

    typedef struct packed {
        logic [NSLOT-1:0][CW-1:0] tbl;
        logic [SW-1:0]            ptr;
    } tbl_state_t;

    tbl_state_t state_d, state_q;
    logic       wr_ok;

    always_comb begin
        state_d = state_q;
        wr_ok   = wr_en && (wr_client <= LAST_CLI) && (wr_slot <= LAST_SLOT);
        if (wr_ok) begin
            state_d.tbl[wr_slot] = wr_client;
        end
        if (state_q.ptr == LAST_SLOT) begin
            state_d.ptr = '0;
        end else begin
            state_d.ptr = state_q.ptr + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign owner = state_q.tbl[state_q.ptr];

    // R2: pointer steps by one each cycle
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ptr != LAST_SLOT) |=> (state_q.ptr == $past(state_q.ptr) + SW'(1)));

    // R2: pointer wraps to the first slot
    a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ptr == LAST_SLOT) |=> (state_q.ptr == '0));

    // R7: accepted write is stored at the addressed slot
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_client <= LAST_CLI && wr_slot <= LAST_SLOT)
        |=> (state_q.tbl[$past(wr_slot)] == $past(wr_client)));

    // R8: out-of-range client leaves the table untouched
    a_r8_bad_client_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_client > LAST_CLI) |=> $stable(state_q.tbl));

endmodule

// File: rtl/tdm_grant_pick.sv
module tdm_grant_pick #(
    parameter int unsigned NCLI = tdm_arb_pkg::NUM_CLIENTS,
    localparam int unsigned CW  = $clog2(NCLI),
    localparam int unsigned EXT = 2 ** CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLI-1:0] req,
    input  logic [CW-1:0]   owner,
    output logic [NCLI-1:0] gnt
);

    typedef struct packed {
        logic [NCLI-1:0] gnt;
    } pick_state_t;

    pick_state_t     state_d, state_q;
    logic [EXT-1:0]  req_ext;
    logic [NCLI-1:0] owner_vec;
    logic [NCLI-1:0] low_vec;

    assign req_ext = EXT'(req);

    always_comb begin
        owner_vec = '0;
        for (int i = 0; i < int'(NCLI); i++) begin
            if (CW'(i) == owner) begin
                owner_vec[i] = 1'b1;
            end
        end
        // fixed fallback: lowest requesting index wins
        low_vec = '0;
        for (int i = int'(NCLI) - 1; i >= 0; i--) begin
            if (req[i]) begin
                low_vec    = '0;
                low_vec[i] = 1'b1;
            end
        end
        state_d = state_q;
        if (req_ext[owner]) begin
            state_d.gnt = owner_vec;
        end else begin
            state_d.gnt = low_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign gnt = state_q.gnt;

    // R6: never more than one grant
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q.gnt));

    // R5: idle requests give an empty grant
    a_r5_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (state_q.gnt == '0));

    // R3: requesting owner takes its slot
    a_r3_owner_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_ext[owner] |=> (state_q.gnt == (NCLI'(1) << $past(owner))));

    // R4: fallback picks a requester with no lower requester
    a_r4_lowest_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0 && !req_ext[owner])
        |=> (state_q.gnt != '0
             && (state_q.gnt & $past(req)) == state_q.gnt
             && ((state_q.gnt - NCLI'(1)) & $past(req)) == '0));

endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
    parameter int unsigned NCLI  = tdm_arb_pkg::NUM_CLIENTS,
    parameter int unsigned NSLOT = tdm_arb_pkg::NUM_SLOTS,
    localparam int unsigned CW   = $clog2(NCLI),
    localparam int unsigned SW   = $clog2(NSLOT),
    localparam int unsigned NREG = tdm_arb_pkg::NUM_REGIONS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_region,
    input  logic [SW-1:0]   cfg_slot,
    input  logic [CW-1:0]   cfg_client,
    input  logic [NCLI-1:0] ext_req,
    input  logic [NCLI-1:0] int_req,
    output logic [NCLI-1:0] ext_gnt,
    output logic [NCLI-1:0] int_grant
);

    logic [NREG-1:0][NCLI-1:0] req_arr;
    logic [NREG-1:0][NCLI-1:0] gnt_arr;
    logic [NREG-1:0][CW-1:0]   owner_arr;
    logic [NREG-1:0]           wr_sel;

    assign req_arr[tdm_arb_pkg::REGION_EXT] = ext_req;
    assign req_arr[tdm_arb_pkg::REGION_INT] = int_req;
    assign ext_gnt   = gnt_arr[tdm_arb_pkg::REGION_EXT];
    assign int_grant = gnt_arr[tdm_arb_pkg::REGION_INT];

    for (genvar r = 0; r < int'(NREG); r++) begin : g_region
        assign wr_sel[r] = cfg_we && (cfg_region == 1'(r));

        tdm_slot_table #(
            .NCLI  (NCLI),
            .NSLOT (NSLOT)
        ) i_table (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_sel[r]),
            .wr_slot   (cfg_slot),
            .wr_client (cfg_client),
            .owner     (owner_arr[r])
        );

        tdm_grant_pick #(
            .NCLI (NCLI)
        ) i_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_arr[r]),
            .owner (owner_arr[r]),
            .gnt   (gnt_arr[r])
        );
    end

    // R9: a write aimed at one region never strobes the other
    a_r9_single_region_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

endmodule

// File: tb/test_tdm_slot_arbiter.sv
`timescale 1ns/1ps
module test_tdm_slot_arbiter;

    localparam int NC = 14;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_region = 1'b0;
    logic [5:0]    cfg_slot = '0;
    logic [3:0]    cfg_client = '0;
    logic [NC-1:0] ext_req = '0;
    logic [NC-1:0] int_req = '0;
    logic [NC-1:0] ext_gnt;
    logic [NC-1:0] int_grant;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [NC-1:0] e;
        logic [NC-1:0] i;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    int mt[2][NS];
    int ptr_m = 0;

    always #5 clk = ~clk;

    tdm_slot_arbiter i_tdm_slot_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_region (cfg_region),
        .cfg_slot   (cfg_slot),
        .cfg_client (cfg_client),
        .ext_req    (ext_req),
        .int_req    (int_req),
        .ext_gnt    (ext_gnt),
        .int_grant  (int_grant)
    );

    function automatic logic [NC-1:0] pick(logic [NC-1:0] r, int own);
        if (r[own]) return NC'(1) << own;
        for (int k = 0; k < NC; k++) begin
            if (r[k]) return NC'(1) << k;
        end
        return '0;
    endfunction

    function automatic logic [NC-1:0] mix(int n);
        return NC'((n * 40503 + 12345) ^ (n * n * 7) ^ (n >> 2));
    endfunction

    // Driver: called at a falling edge, leaves at the next falling edge
    task automatic step(input bit we, input bit rg, input int slot, input int cl,
                        input logic [NC-1:0] er, input logic [NC-1:0] ir,
                        input string tag);
        exp_t x;
        cfg_we     = we;
        cfg_region = rg;
        cfg_slot   = 6'(slot);
        cfg_client = 4'(cl);
        ext_req    = er;
        int_req    = ir;
        x.e = pick(er, mt[0][ptr_m]);
        x.i = pick(ir, mt[1][ptr_m]);
        exp_q.push_back(x);
        tag_q.push_back(tag);
        if (we && cl < NC) mt[rg][slot] = cl;
        @(posedge clk);
        ptr_m = (ptr_m + 1) % NS;
        @(negedge clk);
    endtask

    // Monitor: compares each queued expectation after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (ext_gnt !== x.e || int_grant !== x.i) begin
                    errors++;
                    $display("FAIL %s: ext_gnt=%h exp=%h int_grant=%h exp=%h (slot %0d)",
                             t, ext_gnt, x.e, int_grant, x.i, (ptr_m + NS - 1) % NS);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 2; r++)
            for (int s = 0; s < NS; s++) mt[r][s] = 0;

        // R1: grants stay zero while reset is held, even with requests
        ext_req = '1;
        int_req = '1;
        for (int n = 0; n < 3; n++) begin
            @(posedge clk);
            #2;
            checks++;
            if (ext_gnt !== '0 || int_grant !== '0) begin
                errors++;
                $display("FAIL R1: ext_gnt=%h int_grant=%h expected 0 in reset",
                         ext_gnt, int_grant);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        ptr_m = 0;

        // R1 R3 R4: default schedule names client 0 everywhere
        step(0, 0, 0, 0, 14'h0021, 14'h0120, "R1 R3 R4 default table");
        step(0, 0, 0, 0, 14'h0120, 14'h0021, "R1 R3 R4 default table");
        step(0, 0, 0, 0, 14'h2000, 14'h0001, "R1 R4 default table");

        // R5: no requests, pointer still moves (R2)
        for (int n = 0; n < 5; n++) step(0, 0, 0, 0, '0, '0, "R5 R2 idle");

        // R7: program the external schedule, internal one unchanged (R9)
        for (int s = 0; s < NS; s++)
            step(1, 0, s, s % NC, '0, 14'h0003, "R7 R9 program ext");
        // R7: program the internal schedule
        for (int s = 0; s < NS; s++)
            step(1, 1, s, 13 - (s % NC), 14'h0006, '0, "R7 R9 program int");

        // R3 R2 R9: everyone requesting, grants follow each schedule through a wrap
        for (int n = 0; n < 80; n++)
            step(0, 0, 0, 0, '1, '1, "R3 R2 R9 all requesting");

        // R4: owner idle, every other client requesting
        for (int n = 0; n < 30; n++) begin
            logic [NC-1:0] er;
            logic [NC-1:0] ir;
            er = NC'(14'h3FFF) & ~(NC'(1) << mt[0][ptr_m]);
            ir = NC'(14'h3FF0) & ~(NC'(1) << mt[1][ptr_m]);
            step(0, 0, 0, 0, er, ir, "R4 owner idle");
        end

        // R6: mixed patterns, one-hot registered grants
        for (int n = 0; n < 60; n++)
            step(0, 0, 0, 0, mix(n), mix(n + 101), "R6 R3 R4 mixed");

        // R8: invalid client values must not be stored
        step(1, 0, 5, 15, '0, '0, "R8 bad write ext");
        step(1, 1, 9, 14, '0, '0, "R8 bad write int");
        // owner plus client 0 requesting: a dropped write keeps the owner winning
        for (int n = 0; n < NS + 2; n++) begin
            logic [NC-1:0] er;
            logic [NC-1:0] ir;
            er = (NC'(1) << mt[0][ptr_m]) | NC'(1);
            ir = (NC'(1) << mt[1][ptr_m]) | NC'(1);
            step(0, 0, 0, 0, er, ir, "R8 owner kept");
        end

        // R7: write the slot currently being arbitrated; old owner still wins now
        begin
            int k;
            int old;
            k = ptr_m;
            old = mt[0][k];
            step(1, 0, k, 9, (NC'(1) << old) | (NC'(1) << 9), '0, "R7 same-edge write uses old owner");
        end
        for (int n = 0; n < NS + 2; n++) begin
            logic [NC-1:0] er;
            er = (NC'(1) << mt[0][ptr_m]) | NC'(1);
            step(0, 0, 0, 0, er, mix(n + 7), "R7 new owner after write");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule